// File: doc/BRIEF.md
# Dot-Clock Panel Raster Timing Generator

This block produces the raster timing for a parallel RGB panel that is fed one colour component per dot clock, so each pixel spans three clocks. From a single dot clock it derives an active-low horizontal sync, an active-low vertical sync, a data-enable that frames the visible area, a one-clock start-of-frame strobe, and the column and line indices of the clock currently inside the visible area. A pixel fetch engine downstream uses `de`, `col` and `line` to know which data to present. Sync widths, porches and the active size are elaboration-time parameters.

The horizontal wait, which runs from the first clock of sync to the first visible clock, is the sync width plus the back porch multiplied by the clocks-per-pixel factor. With the default numbers this gives a wait of 203 clocks and a line of 1164 clocks. The vertical wait and total are counted in lines and are not scaled, giving a wait of 18 lines and a frame of 259 lines. A `run` input blanks the panel: while it is low every output is idle and both counters rest at zero. Raising it starts a new frame from its first clock.

Top module: `dotclk_timing`

## Requirements
- R1: While `rst` is high, whatever the level of `run`, `hsync_n` and `vsync_n` are 1, and `de`, `sof`, `col` and `line` are 0. A synchronous reset returns both counters to zero.
- R2: A line lasts H_WAIT + H_FRONT + H_ACTIVE clocks. `hsync_n` is 0 for clocks 0 to H_SYNC-1 of every line, including the lines of vertical blanking.
- R3: `de` is 1 only when the horizontal position lies in [H_WAIT, H_WAIT+H_ACTIVE-1] and the vertical position lies in [V_WAIT, V_WAIT+V_ACTIVE-1]. It is 0 during either sync pulse.
- R4: H_WAIT equals H_SYNC + PIX_CLKS*H_BACK. With the defaults, a line is 1164 clocks, 960 clocks of `de` per visible line, and 201 clocks from the end of `hsync_n` to the rise of `de`. The first `de` is 21155 clocks after run starts.
- R5: A frame lasts V_SYNC + V_BACK + V_FRONT + V_ACTIVE lines. `vsync_n` is 0 for all of lines 0 to V_SYNC-1, and the vertical counts are not scaled.
- R6: When `de` is 1, `col` equals the horizontal position minus H_WAIT and `line` equals the vertical position minus V_WAIT. When `de` is 0, both are 0.
- R7: `sof` is 1 for exactly one clock, the first clock of every frame (position 0,0), including the first clock after `run` rises.
- R8: Lowering `run` makes the outputs idle in the same cycle (as in R1) and clears both counters at the next edge. Raising `run` resumes at line 0, clock 0, with `sof` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables scanning; low blanks the panel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, high on visible clocks |
| sof | output | 1 | One-clock start-of-frame strobe |
| col | output | $clog2(H_ACTIVE) (10) | Clock index within the visible line, 0 outside |
| line | output | $clog2(V_ACTIVE) (8) | Line index within the visible area, 0 outside |

## Verification
The bound checker watches relations that hold on every cycle. `de` never overlaps a sync pulse. `col` advances by one and `line` stays constant across consecutive visible clocks. `sof` never lasts two clocks and always coincides with both syncs at the origin. `hsync_n` is never low for longer than its width. Only the bench can confirm the absolute positions of each edge against the arithmetic layout, the tripled back porch at full size, the restart at line 0 after `run` drops mid-line, and the reset override. It does this by comparing every output on every clock of a small configuration over two full frames and more.

// File: rtl/dotclk_timing.sv
module dotclk_timing #(
  parameter int H_ACTIVE = 960,
  parameter int H_SYNC   = 2,
  parameter int H_FRONT  = 1,
  parameter int H_BACK   = 67,
  parameter int PIX_CLKS = 3,
  parameter int V_ACTIVE = 240,
  parameter int V_SYNC   = 2,
  parameter int V_FRONT  = 1,
  parameter int V_BACK   = 16,
  localparam int CW = (H_ACTIVE > 1) ? $clog2(H_ACTIVE) : 1,
  localparam int LW = (V_ACTIVE > 1) ? $clog2(V_ACTIVE) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          de,
  output logic          sof,
  output logic [CW-1:0] col,
  output logic [LW-1:0] line
);
  localparam int H_WAIT  = H_SYNC + PIX_CLKS * H_BACK;
  localparam int H_TOTAL = H_WAIT + H_FRONT + H_ACTIVE;
  localparam int V_WAIT  = V_SYNC + V_BACK;
  localparam int V_TOTAL = V_WAIT + V_FRONT + V_ACTIVE;
  localparam int HW = $clog2(H_TOTAL);
  localparam int VW = $clog2(V_TOTAL);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic h_last, v_last, h_win, v_win, live;

  assign live   = run & ~rst;
  assign h_last = hcnt == HW'(H_TOTAL - 1);
  assign v_last = vcnt == VW'(V_TOTAL - 1);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      hcnt <= '0;
      vcnt <= '0;
    end else begin
      hcnt <= h_last ? '0 : hcnt + 1'b1;
      if (h_last) vcnt <= v_last ? '0 : vcnt + 1'b1;
    end
  end

  assign h_win = (hcnt >= HW'(H_WAIT)) && (hcnt <= HW'(H_WAIT + H_ACTIVE - 1));
  assign v_win = (vcnt >= VW'(V_WAIT)) && (vcnt <= VW'(V_WAIT + V_ACTIVE - 1));

  assign hsync_n = ~(live && hcnt < HW'(H_SYNC));
  assign vsync_n = ~(live && vcnt < VW'(V_SYNC));
  assign de      = live & h_win & v_win;
  assign sof     = live && hcnt == '0 && vcnt == '0;
  assign col     = de ? CW'(hcnt - HW'(H_WAIT)) : '0;
  assign line    = de ? LW'(vcnt - VW'(V_WAIT)) : '0;
endmodule

module dotclk_timing_chk #(
  parameter int H_SYNC = 2,
  parameter int CW = 10,
  parameter int LW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          hsync_n,
  input logic          vsync_n,
  input logic          de,
  input logic          sof,
  input logic [CW-1:0] col,
  input logic [LW-1:0] line
);
  logic [15:0] low_run;

  always_ff @(posedge clk) begin
    if (rst) low_run <= '0;
    else     low_run <= hsync_n ? '0 : low_run + 1'b1;
  end

  p_de_clear_of_sync_r3: assert property (@(posedge clk) disable iff (rst)
    de |-> (hsync_n && vsync_n));

  p_col_advance_r6: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (col == $past(col) + 1'b1));

  p_line_steady_r6: assert property (@(posedge clk) disable iff (rst)
    (de && $past(de)) |-> (line == $past(line)));

  p_sof_single_r7: assert property (@(posedge clk) disable iff (rst)
    sof |=> !sof);

  p_sof_origin_r7: assert property (@(posedge clk) disable iff (rst)
    sof |-> (!hsync_n && !vsync_n && !de && col == '0 && line == '0));

  p_hsync_len_r2: assert property (@(posedge clk) disable iff (rst)
    !hsync_n |-> (low_run < 16'(H_SYNC)));

  p_idle_when_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    !run |-> (hsync_n && vsync_n && !de && !sof));
endmodule

bind dotclk_timing dotclk_timing_chk #(.H_SYNC(H_SYNC), .CW(CW), .LW(LW)) u_chk (.*);

// File: tb/dotclk_timing_test.sv
`timescale 1ns/1ps
module dotclk_timing_test;
  localparam int HA = 6, HS = 2, HF = 1, HB = 2, PX = 3;
  localparam int VA = 4, VS = 1, VF = 1, VB = 2;
  localparam int HWT = HS + PX * HB;
  localparam int HT  = HWT + HF + HA;
  localparam int VWT = VS + VB;
  localparam int VT  = VWT + VF + VA;
  localparam int FR  = HT * VT;

  logic clk = 1'b0, rst = 1'b1, run = 1'b0, run2 = 1'b0;
  always #2.5 clk = ~clk;

  logic hs, vs, de, sof;
  logic [2:0] col;
  logic [1:0] line;
  logic hs2, vs2, de2, sof2;
  logic [9:0] col2;
  logic [7:0] line2;

  dotclk_timing #(.H_ACTIVE(HA), .H_SYNC(HS), .H_FRONT(HF), .H_BACK(HB), .PIX_CLKS(PX),
                  .V_ACTIVE(VA), .V_SYNC(VS), .V_FRONT(VF), .V_BACK(VB)) uut (
    .clk(clk), .rst(rst), .run(run), .hsync_n(hs), .vsync_n(vs), .de(de), .sof(sof),
    .col(col), .line(line));

  dotclk_timing uut_full (
    .clk(clk), .rst(rst), .run(run2), .hsync_n(hs2), .vsync_n(vs2), .de(de2), .sof(sof2),
    .col(col2), .line(line2));

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check_idle(string tag);
    chk({tag, " hsync_n"}, int'(hs), 1);
    chk({tag, " vsync_n"}, int'(vs), 1);
    chk({tag, " de"}, int'(de), 0);
    chk({tag, " sof"}, int'(sof), 0);
    chk({tag, " col"}, int'(col), 0);
    chk({tag, " line"}, int'(line), 0);
  endtask

  task automatic check_at(int t);
    int h = t % HT;
    int v = (t / HT) % VT;
    bit hw = (h >= HWT) && (h < HWT + HA);
    bit vw = (v >= VWT) && (v < VWT + VA);
    bit e  = hw && vw;
    chk("R2 hsync_n", int'(hs), (h < HS) ? 0 : 1);
    chk("R5 vsync_n", int'(vs), (v < VS) ? 0 : 1);
    chk("R3 de", int'(de), int'(e));
    chk("R6 col", int'(col), e ? h - HWT : 0);
    chk("R6 line", int'(line), e ? v - VWT : 0);
    chk("R7 sof", int'(sof), (h == 0 && v == 0) ? 1 : 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) step();
    check_idle("R1 reset");
    run = 1'b1;
    #1;
    check_idle("R1 reset over run");
    step();
    check_idle("R1 reset over run");
    rst = 1'b0;
    #1;
    check_at(0);
    for (int t = 1; t <= 2 * FR + VWT * HT + HWT + 2; t++) begin
      step();
      check_at(t);
    end

    run = 1'b0;
    #1;
    check_idle("R8 stop same cycle");
    for (int i = 0; i < 5; i++) begin
      step();
      check_idle("R8 stopped");
    end
    run = 1'b1;
    #1;
    chk("R8 restart sof", int'(sof), 1);
    check_at(0);
    for (int t = 1; t <= FR + 5; t++) begin
      step();
      check_at(t);
    end

    rst = 1'b1;
    #1;
    check_idle("R1 reset mid-run");
    step();
    check_idle("R1 reset mid-run");
    rst = 1'b0;
    #1;
    check_at(0);
    for (int t = 1; t <= 3 * HT; t++) begin
      step();
      check_at(t);
    end
    run = 1'b0;

    run2 = 1'b1;
    #1;
    chk("R7 full sof", int'(sof2), 1);
    n = 0;
    while (!de2 && n < 30000) begin step(); n++; end
    chk("R4 first de", n, 18 * 1164 + 203);
    chk("R6 full col at start", int'(col2), 0);
    chk("R6 full line at start", int'(line2), 0);
    n = 0;
    while (de2 && n < 2000) begin step(); n++; end
    chk("R4 de width", n, 960);
    n = 0;
    while (hs2 && n < 2000) begin step(); n++; end
    chk("R4 front porch", n, 1);
    n = 0;
    while (!hs2 && n < 2000) begin step(); n++; end
    chk("R2 full hsync width", n, 2);
    n = 0;
    while (!de2 && n < 2000) begin step(); n++; end
    chk("R4 sync end to de", n, 201);
    chk("R6 full line index", int'(line2), 1);
    n = 0;
    while (hs2 && n < 2000) begin step(); n++; end
    chk("R4 line period", n + 203, 1164);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule